// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner with Serial Zero Blanking

This block refreshes a multiplexed seven-segment vacuum fluorescent display from an external digit memory holding a 16-digit BCD number. The memory sits outside the block. Address 0 holds the least significant digit. Read data is combinational and is valid in the same cycle as the address. The display has twelve digit positions, which show memory digits 0 to 11, and one extra indicator position. The indicator position carries three status marks: a memory-held flag, a minus sign and an overflow flag.

A frame visits the indicator position first. It then visits the digit positions from digit 11 down to digit 0, so the scan runs left to right on the glass. Each position is lit for a fixed dwell time and is followed by a short dark gap. The read address is not tied to the lit position. In the first cycles of the indicator slot, the address walks through the four undisplayed high digits (15 down to 12). Their zero status seeds a single blanking flag. As each digit slot ends, that flag carries forward whether the digit just scanned was blanked. One comparison unit therefore handles leading-zero blanking for the whole display.

Top module: `vfd_scan_drv`

## Requirements
- R1: While reset is asserted, and until the first slot after its release, `grid` and `seg` are all zero.
- R2: Each frame lights the indicator position (`grid` bit 12) first, then digit positions 11, 10, … 0 (`grid` bit k for digit k). At most one `grid` bit is high at any time, and `grid` never changes from one lit position directly to another.
- R3: Each position stays lit for DWELL consecutive cycles. It is followed by BLANK cycles in which `grid` and `seg` are both zero.
- R4: A shown digit drives `seg` with bit 0 = segment a through bit 6 = segment g. The codes for 0–9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R5: A digit k is blanked (`seg` = 0) when its value is zero, the digit k+1 to its left was blanked, and k > `dp_pos`. For digit 11, the left neighbour is the chain of hidden digits 15..12.
- R6: The digit at index `dp_pos` is never blanked, and it also lights `seg` bit 7 (decimal point). Digit 0 is never blanked.
- R7: The blanking chain starts in the suppressing state each frame and is then cleared by any non-zero digit among 15..12. A non-zero hidden digit therefore makes all twelve shown digits visible.
- R8: `rd_addr` reads 15, 14, 13, 12 in the first four cycles of the indicator slot. It equals k throughout the slot of digit k.
- R9: In the indicator slot, `seg` bit 0 follows `ind_mem`, bit 6 follows `ind_neg` and bit 3 follows `ind_ovf`. All other bits are zero.
- R10: A digit nibble of 10–15 lights no segments. It counts as non-zero for blanking.
- R11: A zero digit to the right of a non-zero digit is shown as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_data | input | 4 | Digit read from memory at `rd_addr` |
| dp_pos | input | 4 | Index of the digit carrying the decimal point |
| ind_mem | input | 1 | Memory-held indicator |
| ind_neg | input | 1 | Minus indicator |
| ind_ovf | input | 1 | Overflow indicator |
| seg | output | 8 | Segments a–g (bits 0–6) and point (bit 7), registered |
| grid | output | 13 | One-hot position enables, registered |
| rd_addr | output | 4 | Digit memory read address |

## Verification
The checker watches the scan structure on every cycle. It confirms that at most one grid line is lit and that one lit position never hands directly to another. It confirms that segments are dark whenever the grid is dark, that the address matches the lit digit, that the indicator slot drives only its three marks, and that the rightmost digit is never dark when its value is decimal. Whether a given digit should be blanked depends on the whole chain to its left and on the hidden digits. Only the bench scenarios can show this, by comparing full frames against a model built from the requirements. The same holds for the dwell and gap lengths, the frame order and the hidden-digit address walk.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;
  typedef logic [7:0] seg_t;

  localparam seg_t SEG_PT   = 8'h80;
  localparam seg_t MARK_MEM = 8'h01;
  localparam seg_t MARK_NEG = 8'h40;
  localparam seg_t MARK_OVF = 8'h08;

  function automatic seg_t bcd_to_seg(input logic [3:0] d);
    seg_t s;
    case (d)
      4'd0:    s = 8'h3F;
      4'd1:    s = 8'h06;
      4'd2:    s = 8'h5B;
      4'd3:    s = 8'h4F;
      4'd4:    s = 8'h66;
      4'd5:    s = 8'h6D;
      4'd6:    s = 8'h7D;
      4'd7:    s = 8'h07;
      4'd8:    s = 8'h7F;
      4'd9:    s = 8'h6F;
      default: s = 8'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/vfd_slot_timer.sv
module vfd_slot_timer #(
  parameter int SHOWN = 12,
  parameter int DWELL = 1024,
  parameter int BLANK = 8,
  localparam int SLOT_LEN = DWELL + BLANK,
  localparam int CNT_W = $clog2(SLOT_LEN),
  localparam int SLOT_W = $clog2(SHOWN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [SLOT_W-1:0] slot,
  output logic [CNT_W-1:0]  cnt,
  output logic              slot_last,
  output logic              lit
);
  logic [SLOT_W-1:0] slot_d;
  logic [CNT_W-1:0]  cnt_d;
  logic              cnt_en;

  assign slot_last = (cnt == CNT_W'(SLOT_LEN - 1));
  assign lit       = (cnt < CNT_W'(DWELL));
  assign cnt_en    = 1'b1;

  always_comb begin
    slot_d = slot;
    cnt_d  = cnt;
    if (cnt_en) begin
      if (slot_last) begin
        cnt_d  = '0;
        slot_d = (slot == SLOT_W'(SHOWN)) ? '0 : slot + 1'b1;
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      cnt  <= '0;
    end else begin
      slot <= slot_d;
      cnt  <= cnt_d;
    end
  end
endmodule

// File: rtl/vfd_zero_chain.sv
module vfd_zero_chain #(
  parameter int HIDDEN = 4,
  parameter int ADDR_W = 4,
  parameter int DP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_ind,
  input  logic              first,
  input  logic              scan,
  input  logic              slot_last,
  input  logic [ADDR_W-1:0] dig_idx,
  input  logic              zero,
  input  logic [DP_W-1:0]   dp_pos,
  output logic              blank
);
  logic sup_q, sup_d, seed;

  generate
    if (HIDDEN > 0) begin : g_seed
      assign seed = zero;
    end else begin : g_noseed
      assign seed = 1'b1;
    end
  endgenerate

  assign blank = !is_ind && sup_q && zero && (32'(dig_idx) > 32'(dp_pos));

  always_comb begin
    sup_d = sup_q;
    if (is_ind && first)
      sup_d = seed;
    else if (is_ind && scan)
      sup_d = sup_q && zero;
    else if (!is_ind && slot_last)
      sup_d = blank;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_q <= 1'b1;
    else        sup_q <= sup_d;
  end
endmodule

// File: rtl/vfd_seg_select.sv
module vfd_seg_select
  import vfd_scan_pkg::*;
(
  input  logic [3:0] digit,
  input  logic       blank,
  input  logic       pt_here,
  input  logic       is_ind,
  input  logic       ind_mem,
  input  logic       ind_neg,
  input  logic       ind_ovf,
  output seg_t       seg
);
  always_comb begin
    if (is_ind)
      seg = (ind_mem ? MARK_MEM : '0) | (ind_neg ? MARK_NEG : '0) |
            (ind_ovf ? MARK_OVF : '0);
    else if (blank)
      seg = '0;
    else
      seg = bcd_to_seg(digit) | (pt_here ? SEG_PT : '0);
  end
endmodule

// File: rtl/vfd_scan_drv.sv
module vfd_scan_drv
  import vfd_scan_pkg::*;
#(
  parameter int NDIG = 16,
  parameter int SHOWN = 12,
  parameter int DWELL = 1024,
  parameter int BLANK = 8,
  localparam int HIDDEN = NDIG - SHOWN,
  localparam int ADDR_W = $clog2(NDIG),
  localparam int DP_W = $clog2(SHOWN),
  localparam int GRID_W = SHOWN + 1,
  localparam int CNT_W = $clog2(DWELL + BLANK),
  localparam int SLOT_W = $clog2(SHOWN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_data,
  input  logic [DP_W-1:0]   dp_pos,
  input  logic              ind_mem,
  input  logic              ind_neg,
  input  logic              ind_ovf,
  output logic [7:0]        seg,
  output logic [GRID_W-1:0] grid,
  output logic [ADDR_W-1:0] rd_addr
);
  logic              rst_meta, rst_sync_n;
  logic [SLOT_W-1:0] slot;
  logic [CNT_W-1:0]  cnt;
  logic              slot_last, lit, is_ind, scan, blank, pt_here;
  logic [ADDR_W-1:0] dig_idx;
  seg_t              seg_c, seg_d;
  logic [GRID_W-1:0] grid_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  vfd_slot_timer #(.SHOWN(SHOWN), .DWELL(DWELL), .BLANK(BLANK)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .slot(slot), .cnt(cnt),
    .slot_last(slot_last), .lit(lit)
  );

  assign is_ind  = (slot == '0);
  assign dig_idx = ADDR_W'(SHOWN) - ADDR_W'(slot);
  assign scan    = (32'(cnt) < HIDDEN);
  assign pt_here = (32'(dig_idx) == 32'(dp_pos));

  always_comb begin
    if (!is_ind)   rd_addr = dig_idx;
    else if (scan) rd_addr = ADDR_W'(NDIG - 1) - ADDR_W'(cnt);
    else           rd_addr = ADDR_W'(SHOWN);
  end

  vfd_zero_chain #(.HIDDEN(HIDDEN), .ADDR_W(ADDR_W), .DP_W(DP_W)) u_chain (
    .clk(clk), .rst_n(rst_sync_n), .is_ind(is_ind), .first(cnt == '0),
    .scan(scan), .slot_last(slot_last), .dig_idx(dig_idx),
    .zero(rd_data == 4'd0), .dp_pos(dp_pos), .blank(blank)
  );

  vfd_seg_select u_segsel (
    .digit(rd_data), .blank(blank), .pt_here(pt_here), .is_ind(is_ind),
    .ind_mem(ind_mem), .ind_neg(ind_neg), .ind_ovf(ind_ovf), .seg(seg_c)
  );

  always_comb begin
    grid_d = '0;
    seg_d  = '0;
    if (lit) begin
      grid_d = is_ind ? (GRID_W'(1) << SHOWN) : (GRID_W'(1) << dig_idx);
      seg_d  = seg_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grid <= '0;
      seg  <= '0;
    end else if (!rst_sync_n) begin
      grid <= '0;
      seg  <= '0;
    end else begin
      grid <= grid_d;
      seg  <= seg_d;
    end
  end
endmodule

// File: rtl/vfd_scan_chk.sv
module vfd_scan_chk #(
  parameter int SHOWN = 12,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SHOWN:0]    grid,
  input logic [7:0]        seg,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [3:0]        rd_data
);
  // R2
  grid_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grid));

  // R2
  grid_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grid != '0 && $past(grid) != '0) |-> grid == $past(grid));

  // R3
  dark_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grid == '0) |-> (seg == 8'h00));

  // R9
  ind_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grid[SHOWN] |-> ((seg & 8'hB6) == 8'h00));

  // R6
  right_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grid[0] && $past(grid[0]) && $past(rd_data) <= 4'd9) |-> seg != 8'h00);

  genvar k;
  generate
    for (k = 0; k < SHOWN; k++) begin : g_addr
      // R8
      digit_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grid[k] |-> rd_addr == ADDR_W'(k));
    end
  endgenerate
endmodule

bind vfd_scan_drv vfd_scan_chk #(.SHOWN(SHOWN), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .grid(grid), .seg(seg),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/test_vfd_scan_drv.sv
module test_vfd_scan_drv;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL = 12;
  localparam int BLANK = 3;
  localparam int IND = 12;

  logic        clk, rst_n;
  logic [3:0]  rd_data;
  logic [3:0]  dp_pos;
  logic        ind_mem, ind_neg, ind_ovf;
  logic [7:0]  seg;
  logic [12:0] grid;
  logic [3:0]  rd_addr;
  logic [3:0]  mem [16];
  int total, bad;

  assign rd_data = mem[rd_addr];

  vfd_scan_drv #(.NDIG(16), .SHOWN(12), .DWELL(DWELL), .BLANK(BLANK)) i_vfd_scan_drv (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .dp_pos(dp_pos),
    .ind_mem(ind_mem), .ind_neg(ind_neg), .ind_ovf(ind_ovf),
    .seg(seg), .grid(grid), .rd_addr(rd_addr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dec(input logic [3:0] d);
    case (d)
      0: return 8'h3F; 1: return 8'h06; 2: return 8'h5B; 3: return 8'h4F;
      4: return 8'h66; 5: return 8'h6D; 6: return 8'h7D; 7: return 8'h07;
      8: return 8'h7F; 9: return 8'h6F; default: return 8'h00;
    endcase
  endfunction

  task automatic load(input logic [63:0] v, input logic [3:0] dp);
    for (int i = 0; i < 16; i++) mem[i] = v[4*i +: 4];
    dp_pos = dp;
  endtask

  task automatic wait_grid(input logic [12:0] g);
    do @(negedge clk); while (grid != g);
  endtask

  task automatic sync_frame();
    wait_grid('0);
    wait_grid(13'd1 << IND);
    wait_grid('0);
    wait_grid(13'd1 << IND);
  endtask

  task automatic check_frame(input string tag);
    logic sup, blk;
    logic [7:0] e;
    sync_frame();
    e = (ind_mem ? 8'h01 : 8'h00) | (ind_neg ? 8'h40 : 8'h00) | (ind_ovf ? 8'h08 : 8'h00);
    check({tag, " R9 indicator"}, seg, e);
    sup = 1'b1;
    for (int i = 15; i >= 12; i--) sup = sup && (mem[i] == 0);
    for (int k = 11; k >= 0; k--) begin
      wait_grid(13'd1 << k);
      @(negedge clk);
      blk = sup && (mem[k] == 0) && (k > dp_pos);
      e = blk ? 8'h00 : (dec(mem[k]) | ((k == dp_pos) ? 8'h80 : 8'h00));
      check($sformatf("%s %s digit %0d", tag, blk ? "R5" : ((k == dp_pos) ? "R6" : "R4"), k), seg, e);
      sup = blk;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 grid in reset", grid, 0);
    check("R1 seg in reset", seg, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 grid after release", grid, 0);
  endtask

  task automatic t_timing();
    int n;
    sync_frame();
    n = 0;
    while (grid == 13'd1 << IND) begin n++; @(negedge clk); end
    check("R3 dwell length", n, DWELL);
    n = 0;
    while (grid == 0) begin check("R3 gap seg dark", seg, 0); n++; @(negedge clk); end
    check("R3 gap length", n, BLANK);
    for (int k = 11; k >= 0; k--) begin
      check($sformatf("R2 order digit %0d", k), grid, 13'd1 << k);
      while (grid != 0) @(negedge clk);
      while (grid == 0) @(negedge clk);
    end
    check("R2 frame wraps to indicator", grid, 13'd1 << IND);
  endtask

  task automatic t_addr();
    logic [3:0] prev;
    wait_grid('0);
    do begin prev = rd_addr; @(negedge clk); end while (grid != 13'd1 << IND);
    check("R8 hidden walk 15", prev, 15);
    check("R8 hidden walk 14", rd_addr, 14);
    @(negedge clk); check("R8 hidden walk 13", rd_addr, 13);
    @(negedge clk); check("R8 hidden walk 12", rd_addr, 12);
    wait_grid(13'd1 << 11);
    check("R8 digit 11 address", rd_addr, 11);
  endtask

  task automatic t_all_zero();
    load(64'h0, 4'd0);
    check_frame("R5 R6 all zero");
  endtask

  task automatic t_count();
    load(64'h0000_0000_0000_1990, 4'd0);
    check_frame("R5 R11 1990");
    load(64'h0000_0098_7654_3210, 4'd0);
    check_frame("R4 decode");
    load(64'h0000_0000_0100_0205, 4'd0);
    check_frame("R11 inner zeros");
  endtask

  task automatic t_point();
    load(64'h0000_0000_0000_0042, 4'd3);
    check_frame("R6 point at 3");
    load(64'h0000_0000_0000_0000, 4'd11);
    check_frame("R6 point at 11");
  endtask

  task automatic t_hidden();
    load(64'h0010_0000_0000_0000, 4'd2);
    check_frame("R7 hidden 13");
    load(64'h5000_0000_0000_0007, 4'd0);
    check_frame("R7 hidden 15");
  endtask

  task automatic t_marks();
    load(64'h0000_0000_0000_0003, 4'd0);
    ind_mem = 1; ind_neg = 0; ind_ovf = 0; check_frame("R9 mem");
    ind_mem = 0; ind_neg = 1; ind_ovf = 1; check_frame("R9 neg ovf");
    ind_mem = 0; ind_neg = 0; ind_ovf = 0;
  endtask

  task automatic t_nonbcd();
    load(64'h0000_0000_00A0_0000, 4'd0);
    check_frame("R10 nibble A");
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    total = 0; bad = 0;
    ind_mem = 0; ind_neg = 0; ind_ovf = 0;
    load(64'h0, 4'd0);
    t_reset();
    t_timing();
    t_addr();
    t_all_zero();
    t_count();
    t_point();
    t_hidden();
    t_marks();
    t_nonbcd();
    finish_run();
  end
endmodule